// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block keeps track of where the receive engine stands in a circular list of buffer descriptors held in system memory. Software programs a ring base address. Reading that same register back shows the descriptor the hardware is currently using. Each descriptor is two 32-bit words. The first word carries the buffer address. Its bit 0 is the ownership flag (1 = the processor owns the buffer, so hardware may not use it). Its bit 1 marks the last descriptor of the ring.

On each frame-start pulse from the receive logic, the block fetches the first word of the current descriptor through a memory-read request/response port.

- **Descriptor usable (bit 0 = 0):** the buffer address is presented to the payload path until the frame-done pulse. The block then writes the word back with bit 0 set, handing the buffer to the processor. It then steps to the next descriptor, 8 bytes on, or back to the ring base when bit 1 of the fetched word was set.
- **Descriptor owned by the processor:** a sticky "no buffer" flag is raised with a one-cycle event pulse. The frame is dropped and the pointer stays where it is. The same descriptor is tried again only when the next frame starts.

A sticky "frame received" flag, also with an event pulse, reports each stored frame. Both flags are cleared by writing ones.

The memory read request and the write-back use valid/ready. A request stays asserted with an unchanged address (and data) until ready is seen high at a clock edge. The read response has no back-pressure: the block takes it in the cycle `mrd_rsp_valid` is high. Only one read is ever outstanding.

Top module: `rxq_desc_walker`

## Requirements
- R1: After reset the read-back pointer is 0. Both flags and both event pulses are 0. `mrd_req_valid`, `mwr_valid` and `buf_valid` are 0.
- R2: A pointer write sets both the ring base and the current pointer to the written value with bits [1:0] forced to zero, visible on the read-back one cycle later. A pointer write takes priority over an advance in the same cycle.
- R3: A frame start accepted while idle raises `mrd_req_valid` in the next cycle, with `mrd_req_addr` equal to the pointer at frame start. Both are held unchanged until a cycle with `mrd_req_ready` high.
- R4: A read response whose bit 0 is 1 sets the no-buffer flag (`stat_no_buf`) and pulses `evt_no_buf` for one cycle, starting the cycle after the response. No write-back follows and the pointer does not move.
- R5: Every failed fetch sets the flag and pulses the event again, including when it was cleared and no successful fetch happened in between.
- R6: After a failed fetch, no new read is issued until the next frame start.
- R7: A read response whose bit 0 is 0 raises `buf_valid` in the next cycle, with `buf_addr` equal to the word with bits [1:0] zeroed. Both are held until frame done.
- R8: Frame done while a buffer is held raises `mwr_valid` in the next cycle, to the fetched address, with data equal to the fetched word OR 1. In the same cycle `stat_frame_rcvd` is set and `evt_frame_rcvd` pulses. The write is held until `mwr_ready`.
- R9: When the write-back is accepted, the pointer advances by 8, or returns to the ring base if bit 1 of the fetched word was 1.
- R10: `stat_clr_en` with `stat_clr_mask` bit 0 clears the no-buffer flag and bit 1 clears the frame-received flag. A set in the same cycle wins over the clear.
- R11: Frame start is ignored unless the block is idle. Frame done is ignored unless a buffer is held or a frame is being dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qptr_wr_en | input | 1 | Write ring base / current pointer |
| qptr_wr_data | input | AW | Pointer value to write |
| qptr_rd_data | output | AW | Current descriptor address |
| stat_clr_en | input | 1 | Apply write-one-to-clear mask |
| stat_clr_mask | input | 2 | Bit 0 no-buffer, bit 1 frame-received |
| stat_no_buf | output | 1 | Sticky no-buffer flag |
| stat_frame_rcvd | output | 1 | Sticky frame-received flag |
| evt_no_buf | output | 1 | One-cycle pulse per failed fetch |
| evt_frame_rcvd | output | 1 | One-cycle pulse per stored frame |
| frame_start | input | 1 | Pulse: a new frame begins |
| frame_done | input | 1 | Pulse: the current frame has ended |
| buf_valid | output | 1 | A hardware-owned buffer is granted |
| buf_addr | output | AW | Granted buffer address |
| mrd_req_valid | output | 1 | Descriptor read request |
| mrd_req_ready | input | 1 | Memory accepts the read request |
| mrd_req_addr | output | AW | Descriptor address to read |
| mrd_rsp_valid | input | 1 | Read data is valid |
| mrd_rsp_data | input | AW | Descriptor first word |
| mwr_valid | output | 1 | Ownership write-back request |
| mwr_ready | input | 1 | Memory accepts the write |
| mwr_addr | output | AW | Write-back address |
| mwr_data | output | AW | Write-back word |

## Verification
Every output of this block comes from a register, so each result follows its cause by exactly one edge:

- the read request, one cycle after frame start;
- the grant or the no-buffer flag and pulse, one cycle after the response;
- the write-back and frame-received flag, one cycle after frame done;
- the new pointer, one cycle after the write-back handshake or the pointer write.

The bench drives inputs on the falling edge and advances a behavioural model on the rising edge from the same inputs. It compares every output on the next falling edge, so every expectation lands in the cycle the requirement names. Ready and response delay are varied pseudo-randomly, which spreads the handshakes over different cycles.

// File: rtl/rxq_walk_pkg.sv
package rxq_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_HOLD,
    ST_RETIRE,
    ST_SKIP
  } walk_st_t;

  localparam int OWN_POS  = 0;  // 1 = buffer owned by processor
  localparam int WRAP_POS = 1;  // 1 = last descriptor of the ring

  localparam int NFLAG    = 2;
  localparam int FLAG_NB  = 0;  // no buffer available
  localparam int FLAG_RX  = 1;  // frame received
endpackage

// File: rtl/rxq_ring_ptr.sv
module rxq_ring_ptr #(
  parameter int AW        = 32,
  parameter int DESC_WORDS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          adv,
  input  logic          adv_wrap,
  output logic [AW-1:0] cur_ptr
);
  localparam int            WORD_BYTES = 4;
  localparam logic [AW-1:0] STRIDE     = AW'(DESC_WORDS * WORD_BYTES);
  localparam logic [AW-1:0] LOW_MASK   = AW'(WORD_BYTES - 1);

  logic [AW-1:0] base_q;
  logic [AW-1:0] aligned;

  assign aligned = wr_data & ~LOW_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      cur_ptr <= '0;
    end else if (wr_en) begin
      base_q  <= aligned;
      cur_ptr <= aligned;
    end else if (adv) begin
      cur_ptr <= adv_wrap ? base_q : cur_ptr + STRIDE;
    end
  end
endmodule

// File: rtl/rxq_fetch_ctl.sv
module rxq_fetch_ctl
  import rxq_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cur_ptr,
  input  logic          frame_start,
  input  logic          frame_done,
  output logic          mrd_req_valid,
  input  logic          mrd_req_ready,
  output logic [AW-1:0] mrd_req_addr,
  input  logic          mrd_rsp_valid,
  input  logic [AW-1:0] mrd_rsp_data,
  output logic          mwr_valid,
  input  logic          mwr_ready,
  output logic [AW-1:0] mwr_addr,
  output logic [AW-1:0] mwr_data,
  output logic          buf_valid,
  output logic [AW-1:0] buf_addr,
  output logic          adv,
  output logic          adv_wrap,
  output logic          hit_no_buf,
  output logic          hit_rcvd
);
  localparam logic [AW-1:0] LOW_MASK = AW'(3);
  localparam logic [AW-1:0] OWN_MASK = AW'(1) << OWN_POS;

  walk_st_t      st;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] desc_q;
  logic          owned;

  assign owned = mrd_rsp_data[OWN_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      desc_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE:   if (frame_start) begin
                     addr_q <= cur_ptr;
                     st     <= ST_FETCH;
                   end
        ST_FETCH:  if (mrd_req_ready) st <= ST_WAIT;
        ST_WAIT:   if (mrd_rsp_valid) begin
                     if (owned) begin
                       st <= ST_SKIP;
                     end else begin
                       desc_q <= mrd_rsp_data;
                       st     <= ST_HOLD;
                     end
                   end
        ST_HOLD:   if (frame_done) st <= ST_RETIRE;
        ST_RETIRE: if (mwr_ready) st <= ST_IDLE;
        ST_SKIP:   if (frame_done) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign mrd_req_valid = (st == ST_FETCH);
  assign mrd_req_addr  = addr_q;
  assign mwr_valid     = (st == ST_RETIRE);
  assign mwr_addr      = addr_q;
  assign mwr_data      = desc_q | OWN_MASK;
  assign buf_valid     = (st == ST_HOLD);
  assign buf_addr      = desc_q & ~LOW_MASK;
  assign adv           = (st == ST_RETIRE) && mwr_ready;
  assign adv_wrap      = desc_q[WRAP_POS];
  assign hit_no_buf    = (st == ST_WAIT) && mrd_rsp_valid && owned;
  assign hit_rcvd      = (st == ST_HOLD) && frame_done;
endmodule

// File: rtl/rxq_status_flags.sv
module rxq_status_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flag_vec,
  output logic [N-1:0] evt_vec
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_vec[i] <= 1'b0;
        evt_vec[i]  <= 1'b0;
      end else begin
        flag_vec[i] <= set_vec[i] | (flag_vec[i] & ~(clr_en & clr_mask[i]));
        evt_vec[i]  <= set_vec[i];
      end
    end
  end
endmodule

// File: rtl/rxq_desc_walker.sv
module rxq_desc_walker
  import rxq_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qptr_wr_en,
  input  logic [AW-1:0] qptr_wr_data,
  output logic [AW-1:0] qptr_rd_data,
  input  logic          stat_clr_en,
  input  logic [1:0]    stat_clr_mask,
  output logic          stat_no_buf,
  output logic          stat_frame_rcvd,
  output logic          evt_no_buf,
  output logic          evt_frame_rcvd,
  input  logic          frame_start,
  input  logic          frame_done,
  output logic          buf_valid,
  output logic [AW-1:0] buf_addr,
  output logic          mrd_req_valid,
  input  logic          mrd_req_ready,
  output logic [AW-1:0] mrd_req_addr,
  input  logic          mrd_rsp_valid,
  input  logic [AW-1:0] mrd_rsp_data,
  output logic          mwr_valid,
  input  logic          mwr_ready,
  output logic [AW-1:0] mwr_addr,
  output logic [AW-1:0] mwr_data
);
  logic [AW-1:0]    cur_ptr;
  logic             adv, adv_wrap;
  logic             hit_no_buf, hit_rcvd;
  logic [NFLAG-1:0] set_vec, flag_vec, evt_vec;

  rxq_ring_ptr #(.AW(AW), .DESC_WORDS(2)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (qptr_wr_en),
    .wr_data  (qptr_wr_data),
    .adv      (adv),
    .adv_wrap (adv_wrap),
    .cur_ptr  (cur_ptr)
  );

  rxq_fetch_ctl #(.AW(AW)) u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur_ptr       (cur_ptr),
    .frame_start   (frame_start),
    .frame_done    (frame_done),
    .mrd_req_valid (mrd_req_valid),
    .mrd_req_ready (mrd_req_ready),
    .mrd_req_addr  (mrd_req_addr),
    .mrd_rsp_valid (mrd_rsp_valid),
    .mrd_rsp_data  (mrd_rsp_data),
    .mwr_valid     (mwr_valid),
    .mwr_ready     (mwr_ready),
    .mwr_addr      (mwr_addr),
    .mwr_data      (mwr_data),
    .buf_valid     (buf_valid),
    .buf_addr      (buf_addr),
    .adv           (adv),
    .adv_wrap      (adv_wrap),
    .hit_no_buf    (hit_no_buf),
    .hit_rcvd      (hit_rcvd)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLAG_NB] = hit_no_buf;
    set_vec[FLAG_RX] = hit_rcvd;
  end

  rxq_status_flags #(.N(NFLAG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_en   (stat_clr_en),
    .clr_mask (stat_clr_mask),
    .flag_vec (flag_vec),
    .evt_vec  (evt_vec)
  );

  assign qptr_rd_data    = cur_ptr;
  assign stat_no_buf     = flag_vec[FLAG_NB];
  assign stat_frame_rcvd = flag_vec[FLAG_RX];
  assign evt_no_buf      = evt_vec[FLAG_NB];
  assign evt_frame_rcvd  = evt_vec[FLAG_RX];
endmodule

// File: rtl/rxq_walk_checker.sv
module rxq_walk_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          qptr_wr_en,
  input logic [AW-1:0] qptr_rd_data,
  input logic          stat_no_buf,
  input logic          stat_frame_rcvd,
  input logic          evt_no_buf,
  input logic          evt_frame_rcvd,
  input logic          buf_valid,
  input logic          mrd_req_valid,
  input logic          mrd_req_ready,
  input logic [AW-1:0] mrd_req_addr,
  input logic          mwr_valid,
  input logic          mwr_ready,
  input logic [AW-1:0] mwr_addr,
  input logic [AW-1:0] mwr_data
);
  // R3: a stalled read request keeps valid and address
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req_valid && !mrd_req_ready) |=> (mrd_req_valid && $stable(mrd_req_addr)));

  // R8: a stalled write-back keeps valid, address and data
  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_valid && !mwr_ready) |=> (mwr_valid && $stable(mwr_addr) && $stable(mwr_data)));

  // R4: an event pulse is always accompanied by the sticky flag
  assert_nb_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_no_buf |-> (stat_no_buf && !buf_valid));

  // R8: frame-received pulse is accompanied by the sticky flag
  assert_rx_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_rcvd |-> stat_frame_rcvd);

  // R9: pointer moves only on a pointer write or an accepted write-back
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!qptr_wr_en && !(mwr_valid && mwr_ready)) |=> $stable(qptr_rd_data));

  // R11: at most one of fetch, grant and write-back is active
  assert_one_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mrd_req_valid, buf_valid, mwr_valid}));
endmodule

bind rxq_desc_walker rxq_walk_checker #(.AW(AW)) u_walk_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .qptr_wr_en      (qptr_wr_en),
  .qptr_rd_data    (qptr_rd_data),
  .stat_no_buf     (stat_no_buf),
  .stat_frame_rcvd (stat_frame_rcvd),
  .evt_no_buf      (evt_no_buf),
  .evt_frame_rcvd  (evt_frame_rcvd),
  .buf_valid       (buf_valid),
  .mrd_req_valid   (mrd_req_valid),
  .mrd_req_ready   (mrd_req_ready),
  .mrd_req_addr    (mrd_req_addr),
  .mwr_valid       (mwr_valid),
  .mwr_ready       (mwr_ready),
  .mwr_addr        (mwr_addr),
  .mwr_data        (mwr_data)
);

// File: tb/tb_rxq_desc_walker.sv
module tb_rxq_desc_walker;
  localparam int AW = 32;

  logic          clk, rst_n;
  logic          qptr_wr_en = 0;
  logic [AW-1:0] qptr_wr_data = '0;
  logic [AW-1:0] qptr_rd_data;
  logic          stat_clr_en = 0;
  logic [1:0]    stat_clr_mask = '0;
  logic          stat_no_buf, stat_frame_rcvd, evt_no_buf, evt_frame_rcvd;
  logic          frame_start = 0, frame_done = 0;
  logic          buf_valid;
  logic [AW-1:0] buf_addr;
  logic          mrd_req_valid, mrd_req_ready;
  logic [AW-1:0] mrd_req_addr;
  logic          mrd_rsp_valid;
  logic [AW-1:0] mrd_rsp_data;
  logic          mwr_valid, mwr_ready;
  logic [AW-1:0] mwr_addr, mwr_data;

  rxq_desc_walker #(.AW(AW)) dut (.*);

  initial begin clk = 0; forever #10 clk = ~clk; end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] mem [64];
  logic [15:0] lfsr = 16'hACE1;
  bit          rdy_rand = 0;
  bit          rd_seen = 0;
  logic [31:0] rd_seen_addr = '0;
  bit          pend = 0;
  int          pcnt = 0;
  logic [31:0] paddr = '0;
  int          n_rd = 0, n_wr = 0;

  always @(posedge clk) begin
    rd_seen = rst_n && mrd_req_valid && mrd_req_ready;
    rd_seen_addr = mrd_req_addr;
    if (rd_seen) n_rd++;
    if (rst_n && mwr_valid && mwr_ready) begin
      mem[mwr_addr[7:2]] = mwr_data;
      n_wr++;
    end
  end

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mrd_req_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    mwr_ready     = rdy_rand ? (lfsr[1] | lfsr[6]) : 1'b1;
    mrd_rsp_valid = 1'b0;
    if (rd_seen) begin
      pend = 1; paddr = rd_seen_addr;
      pcnt = rdy_rand ? int'(lfsr[5:4] % 3) : 0;
      rd_seen = 0;
    end
    if (pend) begin
      if (pcnt == 0) begin
        mrd_rsp_valid = 1'b1;
        mrd_rsp_data  = mem[paddr[7:2]];
        pend = 0;
      end else pcnt--;
    end
  end

  // ---------------- behavioural reference ----------------
  // phase: 0 idle, 1 asking, 2 awaiting data, 3 granted, 4 returning, 5 discarding
  int          ph = 0;
  logic [31:0] m_base = 0, m_cur = 0, m_addr = 0, m_word = 0;
  bit          m_nb = 0, m_rx = 0, m_enb = 0, m_erx = 0;

  always @(posedge clk) begin
    bit snb, srx, step;
    if (!rst_n) begin
      ph = 0; m_base = 0; m_cur = 0; m_addr = 0; m_word = 0;
      m_nb = 0; m_rx = 0; m_enb = 0; m_erx = 0;
    end else begin
      snb = 0; srx = 0; step = 0;
      if (ph == 0 && frame_start) begin m_addr = m_cur; ph = 1; end
      else if (ph == 1 && mrd_req_ready) ph = 2;
      else if (ph == 2 && mrd_rsp_valid) begin
        if (mrd_rsp_data[0]) begin snb = 1; ph = 5; end
        else begin m_word = mrd_rsp_data; ph = 3; end
      end
      else if (ph == 3 && frame_done) begin srx = 1; ph = 4; end
      else if (ph == 4 && mwr_ready) begin step = 1; ph = 0; end
      else if (ph == 5 && frame_done) ph = 0;
      if (qptr_wr_en) begin m_base = qptr_wr_data & ~32'h3; m_cur = m_base; end
      else if (step) m_cur = m_word[1] ? m_base : m_cur + 8;
      m_nb = snb || (m_nb && !(stat_clr_en && stat_clr_mask[0]));
      m_rx = srx || (m_rx && !(stat_clr_en && stat_clr_mask[1]));
      m_enb = snb; m_erx = srx;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 qptr_rd_data", qptr_rd_data, m_cur);
      check("R3 mrd_req_valid", 32'(mrd_req_valid), 32'(ph == 1));
      if (ph == 1) check("R3 mrd_req_addr", mrd_req_addr, m_addr);
      check("R4 stat_no_buf", 32'(stat_no_buf), 32'(m_nb));
      check("R5 evt_no_buf", 32'(evt_no_buf), 32'(m_enb));
      check("R7 buf_valid", 32'(buf_valid), 32'(ph == 3));
      if (ph == 3) check("R7 buf_addr", buf_addr, m_word & ~32'h3);
      check("R8 mwr_valid", 32'(mwr_valid), 32'(ph == 4));
      if (ph == 4) begin
        check("R8 mwr_addr", mwr_addr, m_addr);
        check("R8 mwr_data", mwr_data, m_word | 32'h1);
      end
      check("R8 stat_frame_rcvd", 32'(stat_frame_rcvd), 32'(m_rx));
      check("R8 evt_frame_rcvd", 32'(evt_frame_rcvd), 32'(m_erx));
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ptr(input logic [31:0] v);
    @(negedge clk); qptr_wr_en = 1; qptr_wr_data = v;
    @(negedge clk); qptr_wr_en = 0;
  endtask

  task automatic clear(input logic [1:0] m);
    @(negedge clk); stat_clr_en = 1; stat_clr_mask = m;
    @(negedge clk); stat_clr_en = 0; stat_clr_mask = 0;
  endtask

  task automatic frame(input bit extra_start, input bit clr_rx_at_done);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    while (ph != 3 && ph != 5) @(negedge clk);
    if (extra_start) begin frame_start = 1; @(negedge clk); frame_start = 0; end
    idle(2);
    frame_done = 1;
    if (clr_rx_at_done) begin stat_clr_en = 1; stat_clr_mask = 2'b10; end
    @(negedge clk); frame_done = 0; stat_clr_en = 0; stat_clr_mask = 0;
    while (ph != 0) @(negedge clk);
    idle(1);
  endtask

  initial begin
    int rd0, wr0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h1;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 qptr", qptr_rd_data, 0);
    check("R1 flags", {stat_no_buf, stat_frame_rcvd, evt_no_buf, evt_frame_rcvd}, 0);
    check("R1 reqs", {mrd_req_valid, mwr_valid, buf_valid}, 0);

    // R2 alignment
    write_ptr(32'h0000_0103);
    check("R2 aligned", qptr_rd_data, 32'h100);

    // R4 owned descriptor: drop, no write, pointer unchanged
    mem[0] = 32'h0000_2001;
    wr0 = n_wr;
    frame(0, 0);
    check("R4 no_buf set", 32'(stat_no_buf), 1);
    check("R4 ptr kept", qptr_rd_data, 32'h100);
    check("R4 no write", n_wr, wr0);

    // R10 clear, then R5 re-set on a further failure
    clear(2'b01);
    check("R10 no_buf cleared", 32'(stat_no_buf), 0);
    frame(0, 0);
    check("R5 no_buf again", 32'(stat_no_buf), 1);

    // R6 no retry without a frame start
    rd0 = n_rd;
    idle(20);
    check("R6 no reread", n_rd, rd0);

    // R11 frame done while idle is ignored
    clear(2'b11);
    wr0 = n_wr;
    @(negedge clk); frame_done = 1; @(negedge clk); frame_done = 0;
    idle(3);
    check("R11 done ignored", {n_wr - wr0, 32'(stat_frame_rcvd)}, 0);

    // R7/R8/R9 successful frame after the processor frees the buffer
    rdy_rand = 1;
    mem[0] = 32'h0000_2000;
    mem[2] = 32'h0000_3000;
    mem[4] = 32'h0000_4002;
    frame(0, 0);
    check("R8 rcvd set", 32'(stat_frame_rcvd), 1);
    check("R8 owner written", mem[0], 32'h2001);
    check("R9 advance", qptr_rd_data, 32'h108);

    // R11 extra frame start while granted is ignored; R10 set wins over clear
    rd0 = n_rd;
    frame(1, 1);
    check("R11 one read", n_rd - rd0, 1);
    check("R10 set wins", 32'(stat_frame_rcvd), 1);
    check("R9 advance2", qptr_rd_data, 32'h110);

    // R9 wrap back to base
    frame(0, 0);
    check("R9 wrap", qptr_rd_data, 32'h100);
    check("R8 wrap owner", mem[4], 32'h4003);

    // ring exhausted: all owned again, next frame fails
    frame(0, 0);
    check("R5 exhausted", 32'(evt_no_buf | stat_no_buf), 1);

    // R2 pointer write mid-run relocates base
    write_ptr(32'h0000_0122);
    check("R2 relocate", qptr_rd_data, 32'h120);

    idle(4);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule